// File: doc/BRIEF.md
# Key-Protected Pin Function Register

This block holds the configuration that decides what each of four port pins does. A plain function register gives every pin a 4-bit mode field. When a field holds the value 1, that pin is handed to the serial-interface alternate function. Any other value leaves the pin under general-purpose control, and reset clears every field to zero, which is the GPIO default.

A second, guarded register holds the choice between the SPI and I2C variants of the serial alternate. Software changes it with three back-to-back bus writes:

1. An opening key.
2. The new value, which the block keeps in a pending stage.
3. A sealing key.

The live guarded value changes only when the sealing key arrives correctly as the very next write. Any other write, or a wrong key, abandons the attempt and drops the pending value.

The bus is a simple synchronous write port with a combinational read. Reads never disturb an unlock attempt in progress. Only writes count as steps of the sequence.

Top module: `pinfn_regs`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `pin_mode`, `pin_serial`, `serial_i2c` and the read-back of every address are all zero.
- R2: A write to address 0 (the function register) loads all 16 bits, which appear on `pin_mode` and on reads of address 0 from the next cycle on. Clock cycles without such a write leave `pin_mode` unchanged.
- R3: `pin_serial[i]` is 1 exactly when bits 4i+3..4i of the function register equal 1.
- R4: The guarded register (address 1, 8 bits taken from `bus_wdata[7:0]`) changes only through three consecutive writes: 0x0007 to address 2, then the value to address 1, then 0x0013 to address 3. The new value is live from the cycle after the address-3 write. Both keys are compared over all 16 data bits.
- R5: A write to address 1 that does not directly follow a correct opening key is ignored. A later sealing key does not commit it.
- R6: A wrong opening key, or any write to a different address between the opening key and the address-1 write, aborts the sequence.
- R7: After the address-1 write, a wrong sealing key or any write to another address aborts the sequence and discards the pending value. A later correct sealing key alone then commits nothing.
- R8: Cycles with `bus_we` low between the steps do not break the sequence.
- R9: Reads of addresses 2 and 3 always return zero.
- R10: `serial_i2c` equals bit 1 of the live guarded register (0 selects SPI, 1 selects I2C).
- R11: A correct opening key always starts a fresh sequence, even when it interrupts one already in progress.
- R12: A write that aborts a sequence still has its normal effect; for example, a function-register write still loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 2 | Register address: 0 function, 1 guarded, 2 opening key, 3 sealing key |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| pin_mode | output | 16 | Live function fields, four bits per pin |
| pin_serial | output | 4 | Per-pin flag: the pin uses the serial alternate |
| serial_i2c | output | 1 | Serial variant select: 0 SPI, 1 I2C |

## Verification
The embedded assertions check several things on every cycle:
- The guarded value never moves unless the previous cycle carried a correct sealing-key write.
- The function fields never move without a function-register write.
- A function-register write lands exactly.
- The pending stage is entered only from the armed state.

Whether an abort really discards the pending value, whether a fresh opening key restarts a sequence, and whether idle cycles are tolerated between steps depend on particular orderings of writes. Only the bench's scenarios, checked against its reference model, can show those.

// File: rtl/pinfn_pkg.sv
package pinfn_pkg;

    localparam int DATA_W   = 16;
    localparam int PROT_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int I2C_BIT  = 1;

    localparam logic [DATA_W-1:0] KEY_OPEN = 16'h0007;
    localparam logic [DATA_W-1:0] KEY_SEAL = 16'h0013;

    typedef enum logic [ADDR_W-1:0] {
        RA_FUNC = 2'd0,
        RA_PROT = 2'd1,
        RA_OPEN = 2'd2,
        RA_SEAL = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_PEND  = 2'd2
    } seq_e;

    typedef struct packed {
        logic              we;
        reg_addr_e         addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic key_match(input bus_wr_t w, input reg_addr_e a,
                                       input logic [DATA_W-1:0] k);
        return w.we && (w.addr == a) && (w.data == k);
    endfunction

endpackage

// File: rtl/pinfn_unlock.sv
module pinfn_unlock
    import pinfn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_wr_t           wr,
    output logic              commit,
    output logic [PROT_W-1:0] pend_data
);

    seq_e              state_q, state_d;
    logic [PROT_W-1:0] pend_q,  pend_d;

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        commit  = 1'b0;
        if (wr.we) begin
            if (wr.addr == RA_OPEN) begin
                state_d = key_match(wr, RA_OPEN, KEY_OPEN) ? SQ_ARMED : SQ_IDLE;
            end else if (wr.addr == RA_PROT && state_q == SQ_ARMED) begin
                state_d = SQ_PEND;
                pend_d  = wr.data[PROT_W-1:0];
            end else if (state_q == SQ_PEND && key_match(wr, RA_SEAL, KEY_SEAL)) begin
                state_d = SQ_IDLE;
                commit  = 1'b1;
            end else begin
                state_d = SQ_IDLE;
            end
        end
        if (state_d != SQ_PEND) pend_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    assign pend_data = pend_q;

    // R6: the pending stage is only ever entered from an armed sequence
    a_r6_pend_from_armed: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_PEND && $past(state_q) != SQ_PEND) |->
            $past(state_q == SQ_ARMED && wr.we && wr.addr == RA_PROT));

    // R11: a correct opening key always arms
    a_r11_open_arms: assert property (@(posedge clk) disable iff (rst)
        key_match(wr, RA_OPEN, KEY_OPEN) |=> state_q == SQ_ARMED);

    // R7: outside the pending stage nothing is held
    a_r7_no_stale_pending: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_PEND) |-> pend_q == '0);

endmodule

// File: rtl/pinfn_decode.sv
module pinfn_decode #(
    parameter int NUM_PINS = 4,
    parameter int FIELD_W  = 4,
    parameter int SER_CODE = 1,
    localparam int FUNC_W  = NUM_PINS * FIELD_W
) (
    input  logic [FUNC_W-1:0]   func,
    output logic [NUM_PINS-1:0] pin_serial
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign pin_serial[p] = (func[p*FIELD_W +: FIELD_W] == FIELD_W'(SER_CODE));
    end

endmodule

// File: rtl/pinfn_regs.sv
module pinfn_regs
    import pinfn_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int FIELD_W  = 4,
    localparam int FUNC_W  = NUM_PINS * FIELD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [FUNC_W-1:0]   pin_mode,
    output logic [NUM_PINS-1:0] pin_serial,
    output logic                serial_i2c
);

    bus_wr_t           wr;
    logic [FUNC_W-1:0] func_q;
    logic [PROT_W-1:0] prot_q;
    logic              commit;
    logic [PROT_W-1:0] pend_data;

    assign wr.we   = bus_we;
    assign wr.addr = reg_addr_e'(bus_addr);
    assign wr.data = bus_wdata;

    pinfn_unlock u_unlock (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .commit    (commit),
        .pend_data (pend_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            func_q <= '0;
            prot_q <= '0;
        end else begin
            if (wr.we && wr.addr == RA_FUNC) func_q <= wr.data[FUNC_W-1:0];
            if (commit)                      prot_q <= pend_data;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (wr.addr)
            RA_FUNC: bus_rdata[FUNC_W-1:0] = func_q;
            RA_PROT: bus_rdata[PROT_W-1:0] = prot_q;
            default: bus_rdata = '0;
        endcase
    end

    pinfn_decode #(.NUM_PINS(NUM_PINS), .FIELD_W(FIELD_W), .SER_CODE(1)) u_decode (
        .func       (func_q),
        .pin_serial (pin_serial)
    );

    assign pin_mode   = func_q;
    assign serial_i2c = prot_q[I2C_BIT];

    // R4: guarded value moves only after a correct sealing write
    a_r4_commit_needs_seal: assert property (@(posedge clk) disable iff (rst)
        !$stable(prot_q) |->
            $past(bus_we && bus_addr == RA_SEAL && bus_wdata == KEY_SEAL));

    // R2: a function write lands exactly
    a_r2_func_loads: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == RA_FUNC) |=> pin_mode == $past(bus_wdata[FUNC_W-1:0]));

    // R2: without a function write the fields hold
    a_r2_func_holds: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == RA_FUNC) |=> $stable(pin_mode));

    // R9: key addresses never expose data
    a_r9_keys_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == RA_OPEN || bus_addr == RA_SEAL) |-> bus_rdata == '0);

endmodule

// File: tb/test_pinfn_regs.sv
module test_pinfn_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_mode;
    logic [3:0]  pin_serial;
    logic        serial_i2c;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    int m_func = 0, m_prot = 0, m_pend = 0, m_stage = 0;

    always #2 clk = ~clk;

    pinfn_regs i_pinfn_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_mode(pin_mode),
        .pin_serial(pin_serial), .serial_i2c(serial_i2c)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model: stage 0 idle, 1 opened, 2 value held
    always @(posedge clk) begin
        if (rst) begin
            m_func <= 0; m_prot <= 0; m_pend <= 0; m_stage <= 0;
        end else if (bus_we) begin
            m_stage <= 0;
            case (bus_addr)
                2'd0: m_func <= int'(bus_wdata);
                2'd1: if (m_stage == 1) begin
                          m_pend <= int'(bus_wdata[7:0]); m_stage <= 2;
                      end
                2'd2: if (bus_wdata == 16'h0007) m_stage <= 1;
                default: if (m_stage == 2 && bus_wdata == 16'h0013) m_prot <= m_pend;
            endcase
        end
    end

    function automatic int exp_serial(input int f);
        int s = 0;
        for (int p = 0; p < 4; p++)
            if (((f >> (4*p)) & 15) == 1) s |= (1 << p);
        return s;
    endfunction

    function automatic int exp_rdata(input int a);
        if (a == 0) return m_func;
        if (a == 1) return m_prot;
        return 0;
    endfunction

    // compare against the model on every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 pin_mode",    int'(pin_mode),   m_func);
            chk("R3 pin_serial",  int'(pin_serial), exp_serial(m_func));
            chk("R10 serial_i2c", int'(serial_i2c), (m_prot >> 1) & 1);
            chk("R9 bus_rdata",   int'(bus_rdata),  exp_rdata(int'(bus_addr)));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_we = 1'b0;
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        v = int'(bus_rdata);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_mode",   int'(pin_mode),   0);
        chk("R1 pin_serial", int'(pin_serial), 0);
        chk("R1 serial_i2c", int'(serial_i2c), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk("R1 readback", v, 0);
        end

        // R2/R3 function fields
        wr(2'd0, 16'h1111); idle(1); @(negedge clk);
        chk("R3 all serial", int'(pin_serial), 4'hF);
        wr(2'd0, 16'h2101); idle(1); @(negedge clk);
        chk("R3 mixed fields", int'(pin_serial), 4'b0101);
        rd(2'd0, v); chk("R2 func readback", v, 16'h2101);

        // R5 unkeyed guarded write ignored, lone seal commits nothing
        wr(2'd1, 16'h0002); wr(2'd3, 16'h0013); idle(1);
        rd(2'd1, v); chk("R5 unkeyed ignored", v, 0);

        // R4/R10 full sequence
        wr(2'd2, 16'h0007); wr(2'd1, 16'h0002); wr(2'd3, 16'h0013); idle(1);
        @(negedge clk); chk("R10 i2c selected", int'(serial_i2c), 1);
        rd(2'd1, v); chk("R4 committed", v, 8'h02);

        // R8 idle and read cycles between steps
        wr(2'd2, 16'h0007); idle(2); rd(2'd0, v);
        wr(2'd1, 16'h0058); idle(3);
        wr(2'd3, 16'h0013); idle(1);
        rd(2'd1, v); chk("R8 gaps tolerated", v, 8'h58);
        @(negedge clk); chk("R10 spi selected", int'(serial_i2c), 0);

        // R6 wrong opening keys (incl. upper bits) and intervening write
        wr(2'd2, 16'h0006); wr(2'd1, 16'h00FF); wr(2'd3, 16'h0013); idle(1);
        rd(2'd1, v); chk("R6 wrong open key", v, 8'h58);
        wr(2'd2, 16'h0107); wr(2'd1, 16'h00FF); wr(2'd3, 16'h0013); idle(1);
        rd(2'd1, v); chk("R6 open key upper bits", v, 8'h58);
        wr(2'd2, 16'h0007); wr(2'd0, 16'h0001); wr(2'd1, 16'h00FF);
        wr(2'd3, 16'h0013); idle(1);
        rd(2'd1, v); chk("R6 intervening write", v, 8'h58);
        rd(2'd0, v); chk("R12 aborting write applied", v, 16'h0001);

        // R7 wrong seal, then correct seal alone
        wr(2'd2, 16'h0007); wr(2'd1, 16'h00FF); wr(2'd3, 16'h0012);
        wr(2'd3, 16'h0013); idle(1);
        rd(2'd1, v); chk("R7 wrong seal aborts", v, 8'h58);
        wr(2'd2, 16'h0007); wr(2'd1, 16'h00FF); wr(2'd0, 16'h1000);
        wr(2'd3, 16'h0013); idle(1);
        rd(2'd1, v); chk("R7 other write discards", v, 8'h58);
        rd(2'd0, v); chk("R12 func still loads", v, 16'h1000);

        // R11 fresh opening key restarts
        wr(2'd2, 16'h0007); wr(2'd1, 16'h00AA); wr(2'd2, 16'h0007);
        wr(2'd1, 16'h0003); wr(2'd3, 16'h0013); idle(1);
        rd(2'd1, v); chk("R11 restart commits new value", v, 8'h03);

        // R9 key addresses read zero after writes
        rd(2'd2, v); chk("R9 open key reads zero", v, 0);
        rd(2'd3, v); chk("R9 seal key reads zero", v, 0);

        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule